// File: doc/BRIEF.md
# Keyed Power Domain Sequencer

This block controls the power enables of a set of power domains (eight by default) through a small 32-bit register bus. Software first marks domains in a power-up select register or a power-down select register. Nothing changes until it writes a fixed three-word key to a trigger register. There is one key for power-up and another for power-down. After a valid key the controller walks through the selected domains one at a time. Each domain has a programmable order number for power-up and a separate one for power-down, and the smallest number goes first.

For each step the controller drives the domain's enable output to the target level. It then waits until that domain's acknowledge input reaches the same level before it records the new state and moves to the next domain. The live state of every domain can be read back. A status register latches sequence completion and malformed key sequences. An interrupt line combines the status bits that are not masked. Domains 0 and 1 are treated as always on and are never switched off.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the domain state and `pwr_en` equal 0x03 (domains 0 and 1 on). Both select registers read 0. Status reads 0. The interrupt mask reads 0x1FF (all masked). `irq` is 0.
- R2: The power-up select register is at 0x0C and the power-down select register at 0x10; both are read/write. The order registers are at 0x18 + 4*(d/3). In that register domain d's power-down field sits at bits [(d%3)*10 +: 5] and its power-up field at bits [(d%3)*10+5 +: 5]. All order fields read back as written.
- R3: Writing a select register alone changes no domain. A power-up runs only after the writes 0xFF, 0x05, 0x50 to the trigger register at 0x44. A power-down runs only after 0xFF, 0x0A, 0xA0.
- R4: A trigger write of 0xFF always restarts key matching. A wrong second word sets status bit 2, and a wrong third word sets status bit 3. In both cases the key attempt is abandoned and no domain changes.
- R5: Selected domains switch one at a time in ascending order number. Power-up uses the power-up field and power-down uses the power-down field. Equal order numbers go by ascending domain index.
- R6: Each step drives `pwr_en[d]` to the target level. It waits until `pwr_ack[d]` equals that level, then updates the state bit and proceeds. While the acknowledge is missing, the state bit and the other enables stay unchanged.
- R7: A select bit for a domain already in the requested state is skipped. A power-down never turns off domains 0 or 1.
- R8: When a sequence ends, status bit 0 is set and every bit that was in the used select register at commit time is cleared. This also happens when no domain needed switching.
- R9: The register at 0x80 returns the live domain state, one bit per domain, where 1 means on.
- R10: Status reads at 0x8C and also at 0x88. Writing 1 to a bit at either offset clears that bit. Bits 8:4 always read 0.
- R11: The mask register is at 0x48, where 1 means masked. `irq` is the OR of the status bits whose mask bit is 0.
- R12: Offsets not listed read 0. Trigger writes made while a sequence is running are ignored and set no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwr_en | output | 8 | Per-domain power enable |
| pwr_ack | input | 8 | Per-domain power-good acknowledge |
| irq | output | 1 | Combined unmasked status |

## Verification
The bench uses the default parameters: eight domains, 5-bit order fields and domains 0 and 1 always on. With these values the three-fields-per-word layout fills three order registers, so all three cascade addresses are reached, including the partly used last one.

The bench order table contains ties in both directions, so the index tie-break is exercised on power-up and on power-down. A responder in the bench delays each acknowledge by a fixed lag and can hold it off on demand. This makes the wait-for-acknowledge step, and trigger writes that arrive in the middle of a sequence, observable at the ports.

// File: rtl/psq_pkg.sv
package psq_pkg;

  // register offsets
  localparam int unsigned OFS_UP_SEL   = 32'h0C;
  localparam int unsigned OFS_DN_SEL   = 32'h10;
  localparam int unsigned OFS_ORD_BASE = 32'h18;
  localparam int unsigned OFS_TRIGGER  = 32'h44;
  localparam int unsigned OFS_MASK     = 32'h48;
  localparam int unsigned OFS_STATE    = 32'h80;
  localparam int unsigned OFS_ST_ALIAS = 32'h88;
  localparam int unsigned OFS_STATUS   = 32'h8C;

  // trigger key words
  localparam logic [7:0] KEY_OPEN   = 8'hFF;
  localparam logic [7:0] KEY_UP_A   = 8'h05;
  localparam logic [7:0] KEY_UP_B   = 8'h50;
  localparam logic [7:0] KEY_DN_A   = 8'h0A;
  localparam logic [7:0] KEY_DN_B   = 8'hA0;

  // status bit positions
  localparam int unsigned STB_DONE  = 0;
  localparam int unsigned STB_BAD2  = 2;
  localparam int unsigned STB_BAD3  = 3;
  localparam int unsigned STATUS_W  = 9;

  typedef enum logic [1:0] {K_IDLE, K_OPEN, K_UP, K_DN} key_st_t;
  typedef enum logic [1:0] {S_IDLE, S_PICK, S_WAIT}     step_st_t;

  // number of domains whose field pair fits in one 32-bit word
  function automatic int unsigned per_word(input int unsigned ordw);
    return 32 / (2 * ordw);
  endfunction

  // lsb of a domain's order field inside its word (down field first)
  function automatic int unsigned field_lsb(input int unsigned d,
                                            input bit up,
                                            input int unsigned ordw);
    return ((d % per_word(ordw)) * 2 + (up ? 1 : 0)) * ordw;
  endfunction

  // byte offset of the order word that holds domain d
  function automatic int unsigned ord_ofs(input int unsigned d,
                                          input int unsigned ordw);
    return OFS_ORD_BASE + 4 * (d / per_word(ordw));
  endfunction

endpackage

// File: rtl/psq_key_fsm.sv
module psq_key_fsm
  import psq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_we,
  input  logic [7:0] key_val,
  input  logic       busy,
  output logic       go_up,
  output logic       go_dn,
  output logic       bad_second,
  output logic       bad_third
);

  key_st_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= K_IDLE;
      go_up      <= 1'b0;
      go_dn      <= 1'b0;
      bad_second <= 1'b0;
      bad_third  <= 1'b0;
    end else begin
      go_up      <= 1'b0;
      go_dn      <= 1'b0;
      bad_second <= 1'b0;
      bad_third  <= 1'b0;
      if (key_we && !busy) begin
        if (key_val == KEY_OPEN) begin
          st <= K_OPEN;
        end else begin
          unique case (st)
            K_IDLE: st <= K_IDLE;
            K_OPEN: begin
              if (key_val == KEY_UP_A)      st <= K_UP;
              else if (key_val == KEY_DN_A) st <= K_DN;
              else begin
                st         <= K_IDLE;
                bad_second <= 1'b1;
              end
            end
            K_UP: begin
              st <= K_IDLE;
              if (key_val == KEY_UP_B) go_up     <= 1'b1;
              else                     bad_third <= 1'b1;
            end
            K_DN: begin
              st <= K_IDLE;
              if (key_val == KEY_DN_B) go_dn     <= 1'b1;
              else                     bad_third <= 1'b1;
            end
            default: st <= K_IDLE;
          endcase
        end
      end
    end
  end

  AST_COMMIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (go_up || go_dn) |-> !busy); // R12

endmodule

// File: rtl/psq_picker.sv
module psq_picker #(
  parameter int unsigned NDOM  = 8,
  parameter int unsigned ORD_W = 5,
  localparam int unsigned IW   = (NDOM > 1) ? $clog2(NDOM) : 1
) (
  input  logic [NDOM-1:0]             pend,
  input  logic [NDOM-1:0][ORD_W-1:0]  ord,
  output logic [IW-1:0]               pick_idx,
  output logic                        pick_vld
);

  logic [ORD_W-1:0] best_ord;

  // strict less-than keeps the lower index on ties
  always_comb begin
    best_ord = '1;
    pick_idx = '0;
    pick_vld = 1'b0;
    for (int d = 0; d < NDOM; d++) begin
      if (pend[d] && (!pick_vld || (ord[d] < best_ord))) begin
        pick_vld = 1'b1;
        best_ord = ord[d];
        pick_idx = IW'(d);
      end
    end
  end

endmodule

// File: rtl/psq_stepper.sv
module psq_stepper
  import psq_pkg::*;
#(
  parameter int unsigned   NDOM    = 8,
  parameter int unsigned   ORD_W   = 5,
  parameter logic [NDOM-1:0] AON   = 8'h03,
  localparam int unsigned  IW      = (NDOM > 1) ? $clog2(NDOM) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       go_up,
  input  logic                       go_dn,
  input  logic [NDOM-1:0]            up_sel,
  input  logic [NDOM-1:0]            dn_sel,
  input  logic [NDOM-1:0][ORD_W-1:0] ord_up,
  input  logic [NDOM-1:0][ORD_W-1:0] ord_dn,
  input  logic [NDOM-1:0]            pwr_ack,
  output logic [NDOM-1:0]            pwr_en,
  output logic [NDOM-1:0]            dom_on,
  output logic                       busy,
  output logic                       seq_done,
  output logic [NDOM-1:0]            clr_up,
  output logic [NDOM-1:0]            clr_dn
);

  step_st_t                   st;
  logic                       dir_up;
  logic [NDOM-1:0]            pend;
  logic [NDOM-1:0]            snap;
  logic [IW-1:0]              cur;
  logic [NDOM-1:0][ORD_W-1:0] ord_act;
  logic [IW-1:0]              pick_idx;
  logic                       pick_vld;
  logic                       ack_ok;

  assign ord_act = dir_up ? ord_up : ord_dn;

  psq_picker #(.NDOM(NDOM), .ORD_W(ORD_W)) u_pick (
    .pend     (pend),
    .ord      (ord_act),
    .pick_idx (pick_idx),
    .pick_vld (pick_vld)
  );

  assign busy     = (st != S_IDLE);
  assign ack_ok   = (pwr_ack[cur] == dir_up);
  assign seq_done = (st == S_PICK) && !pick_vld;
  assign clr_up   = (seq_done &&  dir_up) ? snap : '0;
  assign clr_dn   = (seq_done && !dir_up) ? snap : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dir_up <= 1'b0;
      pend   <= '0;
      snap   <= '0;
      cur    <= '0;
      pwr_en <= AON;
      dom_on <= AON;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (go_up) begin
            dir_up <= 1'b1;
            snap   <= up_sel;
            pend   <= up_sel & ~dom_on;
            st     <= S_PICK;
          end else if (go_dn) begin
            dir_up <= 1'b0;
            snap   <= dn_sel;
            pend   <= dn_sel & dom_on & ~AON;
            st     <= S_PICK;
          end
        end
        S_PICK: begin
          if (pick_vld) begin
            cur              <= pick_idx;
            pwr_en[pick_idx] <= dir_up;
            st               <= S_WAIT;
          end else begin
            st <= S_IDLE;
          end
        end
        S_WAIT: begin
          if (ack_ok) begin
            dom_on[cur] <= dir_up;
            pend[cur]   <= 1'b0;
            st          <= S_PICK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pwr_en ^ $past(pwr_en)) <= 1); // R5

  AST_STATE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_on != $past(dom_on)) |-> (((dom_on ^ $past(dom_on)) & ($past(pwr_ack) ^ dom_on)) == '0)); // R6

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import psq_pkg::*;
#(
  parameter int unsigned     NDOM  = 8,
  parameter int unsigned     ORD_W = 5,
  parameter int unsigned     AW    = 8,
  parameter logic [NDOM-1:0] AON   = 8'h03
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [NDOM-1:0] pwr_en,
  input  logic [NDOM-1:0] pwr_ack,
  output logic            irq
);

  localparam int unsigned PER      = per_word(ORD_W);
  localparam int unsigned NREG     = (NDOM + PER - 1) / PER;
  localparam int unsigned USED     = PER * 2 * ORD_W;
  localparam logic [31:0] ORD_MASK = 32'((64'd1 << USED) - 64'd1);
  localparam logic [STATUS_W-1:0] LIVE_BITS =
    STATUS_W'((1 << STB_DONE) | (1 << STB_BAD2) | (1 << STB_BAD3));

  logic [NDOM-1:0]            up_sel, dn_sel;
  logic [NREG-1:0][31:0]      ord_word;
  logic [STATUS_W-1:0]        st_mask, status;
  logic [NDOM-1:0][ORD_W-1:0] ord_up, ord_dn;
  logic [NDOM-1:0]            dom_on, clr_up, clr_dn;
  logic                       busy, seq_done;
  logic                       go_up, go_dn, bad_second, bad_third;
  logic                       wr_up, wr_dn, wr_trig, wr_mask, wr_clr;
  logic [STATUS_W-1:0]        st_set, st_clr;

  assign wr_up   = bus_we && (bus_addr == AW'(OFS_UP_SEL));
  assign wr_dn   = bus_we && (bus_addr == AW'(OFS_DN_SEL));
  assign wr_trig = bus_we && (bus_addr == AW'(OFS_TRIGGER));
  assign wr_mask = bus_we && (bus_addr == AW'(OFS_MASK));
  assign wr_clr  = bus_we && ((bus_addr == AW'(OFS_STATUS)) ||
                              (bus_addr == AW'(OFS_ST_ALIAS)));

  // order fields pulled out of the packed words
  for (genvar d = 0; d < NDOM; d++) begin : g_fld
    localparam int unsigned WI  = d / PER;
    localparam int unsigned LUP = field_lsb(d, 1'b1, ORD_W);
    localparam int unsigned LDN = field_lsb(d, 1'b0, ORD_W);
    assign ord_up[d] = ord_word[WI][LUP +: ORD_W];
    assign ord_dn[d] = ord_word[WI][LDN +: ORD_W];
  end

  for (genvar i = 0; i < NREG; i++) begin : g_ord
    localparam logic [AW-1:0] OFS = AW'(OFS_ORD_BASE + 4 * i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         ord_word[i] <= '0;
      else if (bus_we && bus_addr == OFS) ord_word[i] <= bus_wdata & ORD_MASK;
    end
  end

  psq_key_fsm u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_we     (wr_trig),
    .key_val    (bus_wdata[7:0]),
    .busy       (busy),
    .go_up      (go_up),
    .go_dn      (go_dn),
    .bad_second (bad_second),
    .bad_third  (bad_third)
  );

  psq_stepper #(.NDOM(NDOM), .ORD_W(ORD_W), .AON(AON)) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_up    (go_up),
    .go_dn    (go_dn),
    .up_sel   (up_sel),
    .dn_sel   (dn_sel),
    .ord_up   (ord_up),
    .ord_dn   (ord_dn),
    .pwr_ack  (pwr_ack),
    .pwr_en   (pwr_en),
    .dom_on   (dom_on),
    .busy     (busy),
    .seq_done (seq_done),
    .clr_up   (clr_up),
    .clr_dn   (clr_dn)
  );

  always_comb begin
    st_set           = '0;
    st_set[STB_DONE] = seq_done;
    st_set[STB_BAD2] = bad_second;
    st_set[STB_BAD3] = bad_third;
    st_clr           = wr_clr ? bus_wdata[STATUS_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_sel  <= '0;
      dn_sel  <= '0;
      st_mask <= '1;
      status  <= '0;
    end else begin
      up_sel <= (wr_up ? bus_wdata[NDOM-1:0] : up_sel) & ~clr_up;
      dn_sel <= (wr_dn ? bus_wdata[NDOM-1:0] : dn_sel) & ~clr_dn;
      if (wr_mask) st_mask <= bus_wdata[STATUS_W-1:0];
      status <= ((status & ~st_clr) | st_set) & LIVE_BITS;
    end
  end

  assign irq = |(status & ~st_mask);

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (bus_addr == AW'(OFS_ORD_BASE + 4 * i)) bus_rdata = ord_word[i];
    end
    if (bus_addr == AW'(OFS_UP_SEL))   bus_rdata = 32'(up_sel);
    if (bus_addr == AW'(OFS_DN_SEL))   bus_rdata = 32'(dn_sel);
    if (bus_addr == AW'(OFS_MASK))     bus_rdata = 32'(st_mask);
    if (bus_addr == AW'(OFS_STATE))    bus_rdata = 32'(dom_on);
    if (bus_addr == AW'(OFS_STATUS) ||
        bus_addr == AW'(OFS_ST_ALIAS)) bus_rdata = 32'(status);
  end

  AST_AON_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en & AON) == AON); // R7

  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[STB_DONE]) |-> $past(busy)); // R8

  AST_BADKEY_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_second || bad_third) |=> $stable(dom_on)); // R4

endmodule

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pwr_en;
  logic [7:0]  pwr_ack = 8'h03;
  logic        irq;

  always #10 clk = ~clk;  // 50 MHz

  pwr_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_en(pwr_en),
    .pwr_ack(pwr_ack), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // per-domain order numbers used by the bench
  localparam int UP_ORD [8] = '{0, 0, 6, 2, 6, 1, 3, 2};
  localparam int DN_ORD [8] = '{0, 0, 1, 4, 4, 0, 7, 2};

  // {direction up, select, expected state afterwards}
  localparam logic [16:0] VEC [6] = '{
    {1'b1, 8'h3C, 8'h3F},
    {1'b0, 8'h0C, 8'h33},
    {1'b1, 8'hFF, 8'hFF},
    {1'b0, 8'hFF, 8'h03},
    {1'b1, 8'h01, 8'h03},
    {1'b1, 8'hC0, 8'hC3}
  };

  // acknowledge responder and switch recorder
  logic       hold = 1'b0;
  logic [7:0] lag = 8'h03;
  logic [7:0] prev_en = 8'h03;
  int         log_q [16];
  int         log_n = 0;

  initial begin
    forever begin
      @(negedge clk);
      for (int d = 0; d < 8; d++) begin
        if (pwr_en[d] !== prev_en[d] && log_n < 16) begin
          log_q[log_n] = d;
          log_n++;
        end
      end
      prev_en = pwr_en;
      if (!hold) pwr_ack = lag;
      lag = pwr_en;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic key(input bit up);
    wr(8'h44, 32'hFF);
    wr(8'h44, up ? 32'h05 : 32'h0A);
    wr(8'h44, up ? 32'h50 : 32'hA0);
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] v;
    int k;
    k = 0;
    do begin
      rd(8'h8C, v);
      k++;
    end while (!v[0] && k < 400);
    if (!v[0]) begin
      n_cmp++; n_bad++;
      $display("FAIL %s: done bit never set, got %h expected 1", tag, v[0]);
    end
  endtask

  // expected switch order, worked out by selection from the bench tables
  int exp_q [16];
  int exp_n;
  task automatic build_exp(input bit up, input logic [7:0] sel, input logic [7:0] st);
    logic [7:0] left;
    left = up ? (sel & ~st) : (sel & st & 8'hFC);
    exp_n = 0;
    while (left != 0) begin
      int best;
      best = -1;
      for (int d = 0; d < 8; d++) begin
        if (left[d]) begin
          if (best < 0) best = d;
          else if ((up ? UP_ORD[d] : DN_ORD[d]) < (up ? UP_ORD[best] : DN_ORD[best])) best = d;
        end
      end
      exp_q[exp_n] = best;
      exp_n++;
      left[best] = 1'b0;
    end
  endtask

  function automatic logic [31:0] pack_word(input int w);
    logic [31:0] r;
    r = '0;
    for (int j = 0; j < 3; j++) begin
      int d;
      d = w * 3 + j;
      if (d < 8) begin
        r[j*10 +: 5]     = 5'(DN_ORD[d]);
        r[j*10 + 5 +: 5] = 5'(UP_ORD[d]);
      end
    end
    return r;
  endfunction

  initial begin
    repeat (400000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  model;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(8'h80, v); chk("R1 state", v, 32'h03);
    chk("R1 pwr_en", 32'(pwr_en), 32'h03);
    rd(8'h0C, v); chk("R1 up select", v, 0);
    rd(8'h10, v); chk("R1 down select", v, 0);
    rd(8'h8C, v); chk("R1 status", v, 0);
    rd(8'h48, v); chk("R1 mask", v, 32'h1FF);
    chk("R1 irq", 32'(irq), 0);

    // R12 unused offsets
    rd(8'h04, v); chk("R12 unused 0x04", v, 0);
    rd(8'h60, v); chk("R12 unused 0x60", v, 0);

    // R2 order words
    for (int w = 0; w < 3; w++) wr(8'h18 + 8'(4 * w), pack_word(w));
    for (int w = 0; w < 3; w++) begin
      rd(8'h18 + 8'(4 * w), v); chk("R2 order readback", v, pack_word(w));
    end

    // R3 select write without key has no effect
    wr(8'h0C, 32'h08);
    rd(8'h0C, v); chk("R2 up select rw", v, 32'h08);
    repeat (10) @(negedge clk);
    rd(8'h80, v); chk("R3 no key no change", v, 32'h03);
    chk("R3 no key pwr_en", 32'(pwr_en), 32'h03);
    wr(8'h0C, 32'h00);

    // table walk: R5 R7 R8 R9
    model = 8'h03;
    for (int i = 0; i < 6; i++) begin
      logic        up;
      logic [7:0]  sel, exp_st;
      {up, sel, exp_st} = VEC[i];
      build_exp(up, sel, model);
      wr(8'h8C, 32'h1FF);
      wr(up ? 8'h0C : 8'h10, 32'(sel));
      log_n = 0;
      key(up);
      wait_done("R8 table");
      rd(8'h80, v); chk("R9 R7 table state", v, 32'(exp_st));
      chk("R5 switch count", 32'(log_n), 32'(exp_n));
      for (int k = 0; k < exp_n && k < log_n; k++)
        chk("R5 switch order", 32'(log_q[k]), 32'(exp_q[k]));
      rd(up ? 8'h0C : 8'h10, v); chk("R8 select cleared", v, 0);
      rd(8'h8C, v); chk("R8 done only", v, 32'h001);
      model = exp_st;
    end

    // R11 interrupt and R10 alias clear
    chk("R11 irq masked", 32'(irq), 0);
    wr(8'h48, 32'h1FE);
    #1 chk("R11 irq unmasked", 32'(irq), 1);
    wr(8'h88, 32'h001);
    rd(8'h8C, v); chk("R10 alias clear", v, 0);
    chk("R11 irq after clear", 32'(irq), 0);

    // R4 bad third word
    wr(8'h0C, 32'h04);
    wr(8'h44, 32'hFF); wr(8'h44, 32'h05); wr(8'h44, 32'h51);
    repeat (6) @(negedge clk);
    rd(8'h8C, v); chk("R4 bad third", v, 32'h008);
    rd(8'h80, v); chk("R4 state kept", v, 32'hC3);
    wr(8'h48, 32'h1F7);
    #1 chk("R11 irq on fail", 32'(irq), 1);
    wr(8'h8C, 32'h1FF);
    // R4 bad second word
    wr(8'h44, 32'hFF); wr(8'h44, 32'h33);
    repeat (4) @(negedge clk);
    rd(8'h8C, v); chk("R4 bad second", v, 32'h004);
    rd(8'h88, v); chk("R10 alias read", v, 32'h004);
    wr(8'h8C, 32'h1FF);
    wr(8'h0C, 32'h00);

    // R4 restart with 0xFF mid-key, then a valid power-down of domain 7
    wr(8'h10, 32'h80);
    wr(8'h44, 32'hFF); wr(8'h44, 32'h05); wr(8'h44, 32'hFF);
    wr(8'h44, 32'h0A); wr(8'h44, 32'hA0);
    wait_done("R4 restart");
    rd(8'h80, v); chk("R4 restart result", v, 32'h43);
    rd(8'h8C, v); chk("R4 restart no fail", v, 32'h001);
    wr(8'h8C, 32'h1FF);

    // R6 wait for acknowledge, R12 key ignored while busy
    hold = 1'b1;
    wr(8'h0C, 32'h04);
    key(1'b1);
    wr(8'h10, 32'h40);
    key(1'b0);
    repeat (10) @(negedge clk);
    chk("R6 enable driven", 32'(pwr_en), 32'h47);
    rd(8'h80, v); chk("R6 state waits for ack", v, 32'h43);
    hold = 1'b0;
    wait_done("R6 release");
    rd(8'h80, v); chk("R6 state after ack", v, 32'h47);
    repeat (10) @(negedge clk);
    rd(8'h80, v); chk("R12 busy key ignored", v, 32'h47);
    rd(8'h8C, v); chk("R12 no fail bits", v, 32'h001);
    rd(8'h10, v); chk("R12 down select kept", v, 32'h40);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule